// File: doc/BRIEF.md
# Quad-channel double-buffered DAC register controller

This block sits behind a serial frame receiver and holds the digital state of a four-channel voltage-output converter. Each decoded frame carries a strobe, a 3-bit command, a 3-bit channel address and a 16-bit data word. Every channel has two registers. The staging register takes new codes. The output register holds the code that drives the output stage. Codes move from the staging register to the output register only when a command asks for it, or when the channel has been made transparent.

A 4-bit follow mask marks channels as transparent. On every valid write frame, a transparent channel copies its staging register into its output register in that same clock. The other channels keep their output until an update command arrives. Each channel also has a 2-bit output-stage mode: normal, 1 kΩ to ground, 100 kΩ to ground, or high impedance. A soft reset has two depths. Every output is a register and changes on the clock edge that samples the strobe.

Top module: `dacc_ctrl`

## Requirements
- R1: When `rst` is sampled high, all staging and output registers become zero, the follow mask becomes 0 and every channel's mode becomes 00 (normal). Outputs stay zero until a valid write arrives.
- R2: Command 000 writes `frm_dat` into the staging register of each addressed channel. The output of a channel whose mask bit is 0 does not change.
- R3: Command 001 copies the staging register of each addressed channel into its output register. The data word is ignored.
- R4: Command 010 writes the addressed staging register, then loads every channel's output register from its staging register in the same clock.
- R5: Command 011 writes the addressed channel's staging register and its output register to the new code in the same clock.
- R6: Address 000, 001, 010 and 011 select channels A, B, C and D, and address 111 selects all four channels. Commands 000 to 011 sent with address 100, 101 or 110 change nothing.
- R7: Command 100 sets the mode `frm_dat[5:4]` on every channel whose bit is set in `frm_dat[3:0]` (bit 0 is A, bit 3 is D). The codes are 00 normal, 01 1 kΩ, 10 100 kΩ and 11 high impedance. The address is ignored and no code register changes.
- R8: Command 110 loads the follow mask from `frm_dat[3:0]`. On each valid write frame (commands 000, 010 and 011), every channel whose mask bit is 1 loads its output register from its updated staging register in the same clock.
- R9: Command 101 with `frm_dat[0]`=0 clears all staging and output registers and keeps the mask and the modes. With `frm_dat[0]`=1 it also clears the mask and returns every channel to mode 00.
- R10: Command 111 changes nothing. A frame with `frm_stb` low changes nothing.
- R11: `dac_code` packs channel i at bits [16*i+15:16*i], and `pd_mode` packs it at [2*i+1:2*i]. Both change on the edge that samples the strobe and are visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe marking a complete frame |
| frm_cmd | input | 3 | Frame command |
| frm_adr | input | 3 | Frame channel address |
| frm_dat | input | 16 | Frame data word |
| dac_code | output | 64 | Output-register codes, channel A in the low bits |
| pd_mode | output | 8 | Output-stage mode per channel, channel A in the low bits |

## Verification
The hardest state to reach from the ports is a channel that follows its staging register while other channels stay latched. A shallow reset must then leave that mask intact. The only visible trace of the mask is an output that moves on a plain write. The stimulus therefore loads a mixed mask and writes a transparent channel and a latched channel in turn. It then issues the shallow reset, writes again and checks that the transparent channel still follows. A deep reset follows, and a final write shows that the following has stopped.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  typedef enum logic [2:0] {
    CMD_LOAD     = 3'b000,
    CMD_PUSH     = 3'b001,
    CMD_LOAD_ALL = 3'b010,
    CMD_LOAD_GO  = 3'b011,
    CMD_POWER    = 3'b100,
    CMD_SRESET   = 3'b101,
    CMD_MASK     = 3'b110,
    CMD_NONE     = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PD_ON   = 2'b00,
    PD_1K   = 2'b01,
    PD_100K = 2'b10,
    PD_HIZ  = 2'b11
  } pd_e;

  typedef struct packed {
    logic wr;
    logic push_sel;
    logic push_all;
    logic power;
    logic clr_code;
    logic clr_cfg;
    logic mask_ld;
  } ctl_t;

endpackage

// File: rtl/dacc_decode.sv
module dacc_decode
  import dacc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic           stb,
  input  logic [2:0]     cmd,
  input  logic [AW-1:0]  adr,
  input  logic           dat0,
  output ctl_t           ctl,
  output logic [NCH-1:0] sel
);

  localparam logic [AW-1:0] ADR_ALL = {AW{1'b1}};

  logic adr_ok;

  always_comb begin
    sel = '0;
    if (adr == ADR_ALL) begin
      sel = '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (adr == AW'(i)) sel[i] = 1'b1;
      end
    end
  end

  assign adr_ok = |sel;

  always_comb begin
    ctl = '0;
    if (stb) begin
      unique case (cmd_e'(cmd))
        CMD_LOAD:     ctl.wr = adr_ok;
        CMD_PUSH:     ctl.push_sel = adr_ok;
        CMD_LOAD_ALL: begin ctl.wr = adr_ok; ctl.push_all = adr_ok; end
        CMD_LOAD_GO:  begin ctl.wr = adr_ok; ctl.push_sel = adr_ok; end
        CMD_POWER:    ctl.power = 1'b1;
        CMD_SRESET:   begin ctl.clr_code = 1'b1; ctl.clr_cfg = dat0; end
        CMD_MASK:     ctl.mask_ld = 1'b1;
        default:      ctl = '0;
      endcase
    end
  end

  // R6: a selection is either every channel or at most one
  always_comb begin
    a_sel_shape_r6: assert ((&sel) || $onehot0(sel));
  end

endmodule

// File: rtl/dacc_chan.sv
module dacc_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          push,
  input  logic          clr_code,
  input  logic          clr_cfg,
  input  logic          pd_ld,
  input  logic [1:0]    pd_val,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] code,
  output logic [1:0]    pd
);

  logic [DW-1:0] stage_q;
  logic [DW-1:0] stage_nxt;

  assign stage_nxt = wr ? din : stage_q;

  always_ff @(posedge clk) begin
    if (rst || clr_code) begin
      stage_q <= '0;
      code    <= '0;
    end else begin
      stage_q <= stage_nxt;
      if (push) code <= stage_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_cfg) pd <= 2'b00;
    else if (pd_ld)     pd <= pd_val;
  end

  // R2: a latched channel keeps its output without a push or clear
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!push && !clr_code) |=> $stable(code));

  // R7: a mode change leaves the code alone
  p_pd_keeps_code_r7: assert property (@(posedge clk) disable iff (rst)
    pd_ld |=> $stable(code));

  // R9: a soft clear leaves a zero code behind
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
    clr_code |=> (code == '0));

  // R7: the mode only moves on a mode load or deep clear
  p_pd_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!pd_ld && !clr_cfg) |=> $stable(pd));

endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_stb,
  input  logic [2:0]        frm_cmd,
  input  logic [AW-1:0]     frm_adr,
  input  logic [DW-1:0]     frm_dat,
  output logic [NCH*DW-1:0] dac_code,
  output logic [2*NCH-1:0]  pd_mode
);

  localparam int MODE_LSB = NCH;

  ctl_t           ctl;
  logic [NCH-1:0] sel;
  logic [NCH-1:0] follow_q;

  dacc_decode #(.NCH(NCH), .AW(AW)) u_decode (
    .stb  (frm_stb),
    .cmd  (frm_cmd),
    .adr  (frm_adr),
    .dat0 (frm_dat[0]),
    .ctl  (ctl),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst || ctl.clr_cfg) follow_q <= '0;
    else if (ctl.mask_ld)   follow_q <= frm_dat[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic ch_push;
    assign ch_push = (ctl.push_sel & sel[i]) | ctl.push_all | (ctl.wr & follow_q[i]);

    dacc_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr       (ctl.wr & sel[i]),
      .push     (ch_push),
      .clr_code (ctl.clr_code),
      .clr_cfg  (ctl.clr_cfg),
      .pd_ld    (ctl.power & frm_dat[i]),
      .pd_val   (frm_dat[MODE_LSB+1:MODE_LSB]),
      .din      (frm_dat),
      .code     (dac_code[DW*i +: DW]),
      .pd       (pd_mode[2*i +: 2])
    );
  end

  // R1: reset leaves zero codes and normal modes
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && pd_mode == '0));

  // R10: the idle command touches nothing
  p_nop_r10: assert property (@(posedge clk) disable iff (rst)
    (frm_stb && frm_cmd == 3'b111) |=> ($stable(dac_code) && $stable(pd_mode)));

  // R10: no strobe, no change
  p_no_stb_r10: assert property (@(posedge clk) disable iff (rst)
    !frm_stb |=> ($stable(dac_code) && $stable(pd_mode)));

  // R6: code commands with an unused address are dropped
  p_bad_adr_r6: assert property (@(posedge clk) disable iff (rst)
    (frm_stb && !frm_cmd[2] && frm_adr >= AW'(NCH) && frm_adr != {AW{1'b1}})
      |=> $stable(dac_code));

  // R9: a deep reset returns every mode to normal
  p_deep_reset_r9: assert property (@(posedge clk) disable iff (rst)
    (frm_stb && frm_cmd == 3'b101 && frm_dat[0]) |=> (pd_mode == '0));

endmodule

// File: tb/test_dacc_ctrl.sv
module test_dacc_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        frm_stb;
  logic [2:0]  frm_cmd;
  logic [2:0]  frm_adr;
  logic [15:0] frm_dat;
  logic [63:0] dac_code;
  logic [7:0]  pd_mode;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dacc_ctrl i_dacc_ctrl (
    .clk      (clk),
    .rst      (rst),
    .frm_stb  (frm_stb),
    .frm_cmd  (frm_cmd),
    .frm_adr  (frm_adr),
    .frm_dat  (frm_dat),
    .dac_code (dac_code),
    .pd_mode  (pd_mode)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  cmd;
    logic [2:0]  adr;
    logic [15:0] dat;
    logic [63:0] code;
    logic [7:0]  pd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  3'd0, 3'd0, 16'h1111, 64'h0000_0000_0000_0000, 8'h00}, // R2 write only
    '{4'd3,  3'd1, 3'd0, 16'h0000, 64'h0000_0000_0000_1111, 8'h00}, // R3 push A
    '{4'd2,  3'd0, 3'd1, 16'h2222, 64'h0000_0000_0000_1111, 8'h00}, // R2
    '{4'd2,  3'd0, 3'd2, 16'h3333, 64'h0000_0000_0000_1111, 8'h00}, // R2
    '{4'd4,  3'd2, 3'd3, 16'h4444, 64'h4444_3333_2222_1111, 8'h00}, // R4 write D, push all
    '{4'd5,  3'd3, 3'd1, 16'h5555, 64'h4444_3333_5555_1111, 8'h00}, // R5 write+push B
    '{4'd6,  3'd0, 3'd7, 16'h6666, 64'h4444_3333_5555_1111, 8'h00}, // R6 broadcast write
    '{4'd6,  3'd1, 3'd5, 16'h0000, 64'h4444_3333_5555_1111, 8'h00}, // R6 bad address
    '{4'd6,  3'd1, 3'd2, 16'h0000, 64'h4444_6666_5555_1111, 8'h00}, // R6 C
    '{4'd6,  3'd0, 3'd4, 16'h7777, 64'h4444_6666_5555_1111, 8'h00}, // R6 bad address write
    '{4'd6,  3'd1, 3'd7, 16'h0000, 64'h6666_6666_6666_6666, 8'h00}, // R6 push all, 7777 absent
    '{4'd7,  3'd4, 3'd0, 16'h0011, 64'h6666_6666_6666_6666, 8'h01}, // R7 A 1k
    '{4'd7,  3'd4, 3'd5, 16'h002C, 64'h6666_6666_6666_6666, 8'hA1}, // R7 C,D 100k
    '{4'd7,  3'd4, 3'd2, 16'h003A, 64'h6666_6666_6666_6666, 8'hED}, // R7 B,D hiz
    '{4'd7,  3'd4, 3'd7, 16'h0003, 64'h6666_6666_6666_6666, 8'hE0}, // R7 A,B normal
    '{4'd8,  3'd6, 3'd0, 16'h0005, 64'h6666_6666_6666_6666, 8'hE0}, // R8 mask A,C
    '{4'd8,  3'd0, 3'd0, 16'h9999, 64'h6666_6666_6666_9999, 8'hE0}, // R8 A follows
    '{4'd8,  3'd0, 3'd2, 16'hAAAA, 64'h6666_AAAA_6666_9999, 8'hE0}, // R8 C follows
    '{4'd8,  3'd0, 3'd3, 16'hBBBB, 64'h6666_AAAA_6666_9999, 8'hE0}, // R8 D latched
    '{4'd10, 3'd7, 3'd7, 16'hFFFF, 64'h6666_AAAA_6666_9999, 8'hE0}, // R10 idle command
    '{4'd9,  3'd5, 3'd0, 16'h0000, 64'h0000_0000_0000_0000, 8'hE0}, // R9 shallow
    '{4'd9,  3'd0, 3'd0, 16'h1234, 64'h0000_0000_0000_1234, 8'hE0}, // R9 mask kept
    '{4'd9,  3'd5, 3'd0, 16'h0001, 64'h0000_0000_0000_0000, 8'h00}, // R9 deep
    '{4'd9,  3'd0, 3'd0, 16'h4321, 64'h0000_0000_0000_0000, 8'h00}, // R9 mask gone
    '{4'd3,  3'd1, 3'd0, 16'h0000, 64'h0000_0000_0000_4321, 8'h00}  // R3 push A
  };

  task automatic check(input string req, input logic [63:0] ec, input logic [7:0] ep);
    n_chk++;
    if (dac_code !== ec || pd_mode !== ep) begin
      n_err++;
      $display("FAIL %s: code=%h pd=%h expected code=%h pd=%h", req, dac_code, pd_mode, ec, ep);
    end
  endtask

  task automatic frame(input logic stb, input logic [2:0] c, input logic [2:0] a,
                       input logic [15:0] d);
    @(negedge clk);
    frm_stb = stb; frm_cmd = c; frm_adr = a; frm_dat = d;
    @(negedge clk);
    frm_stb = 1'b0;
  endtask

  initial begin
    rst = 1'b1; frm_stb = 1'b0; frm_cmd = '0; frm_adr = '0; frm_dat = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 64'h0, 8'h00);
    // R11 packing is exercised by every table entry
    for (int k = 0; k < NV; k++) begin
      frame(1'b1, TBL[k].cmd, TBL[k].adr, TBL[k].dat);
      check($sformatf("R%0d vec%0d", TBL[k].req, k), TBL[k].code, TBL[k].pd);
    end
    // R10: strobe low with a write-and-push frame
    frame(1'b0, 3'd3, 3'd7, 16'hDEAD);
    check("R10", 64'h0000_0000_0000_4321, 8'h00);
    // R5 broadcast write-and-push, then modes set for the reset test
    frame(1'b1, 3'd3, 3'd7, 16'hFACE);
    check("R5", 64'hFACE_FACE_FACE_FACE, 8'h00);
    frame(1'b1, 3'd4, 3'd0, 16'h003F);
    check("R7", 64'hFACE_FACE_FACE_FACE, 8'hFF);
    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", 64'h0, 8'h00);
    frame(1'b1, 3'd1, 3'd7, 16'h0000);
    check("R1", 64'h0, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule